// File: doc/BRIEF.md
# Shared Interrupt Priority Field Store

This block keeps one 8-bit priority value for every implemented shared interrupt of an interrupt controller. Interrupts numbered below a fixed internal count (per-CPU interrupts handled elsewhere) have no storage here. Software reaches the fields through a simple register port. A request either addresses one field by its byte offset or four adjacent fields as one 32-bit word. Each request carries an attribute that marks it secure or non-secure.

When security is enabled, a non-secure request only sees interrupts whose group input marks them non-secure. For those interrupts it works in a compressed view that covers only the lower-urgency half of the priority range. Secure requests, and every request while the global security-disable input is high, see the stored byte as it is. A one-cycle change pulse tells downstream priority logic that a field was written. Priority comparison and interrupt delivery live outside this block.

Top module: `prio_field_regs`

## Requirements
- R1: After reset every field holds 0x00, so any read returns zero. `rsp_valid` and `field_changed` are low until the first request.
- R2: A secure request, or any request while `sec_disable` is 1, writes the byte to the field unchanged and reads it back unchanged.
- R3: A request is restricted when `req_secure`=0 and `sec_disable`=0. A restricted request to an interrupt whose `group_bits` bit is 0 reads zero for that field and leaves the field unchanged on a write.
- R4: A restricted read of an interrupt whose group bit is 1 returns the stored byte shifted left by one, truncated to 8 bits.
- R5: A restricted write to an interrupt whose group bit is 1 stores 0x80 OR (written byte shifted right by one).
- R6: A word request (`req_word`=1) ignores `req_addr[1:0]` and covers interrupts base..base+3, where base = `req_addr` with bits [1:0] cleared. Interrupt base+k maps to data bits [8k+7:8k].
- R7: A word write is dropped whole when base is below `NUM_INTERNAL`, or when base+3 is not below `NUM_IRQ`. Lanes of a word read that fall outside the implemented range read zero.
- R8: A byte request (`req_word`=0) addresses interrupt `req_addr` and uses data bits [7:0]; `rsp_rdata[31:8]` is zero. A byte request to an interrupt below `NUM_INTERNAL`, or at or above `NUM_IRQ`, reads zero and changes nothing.
- R9: Within one word write, each lane applies the R3 check with its own group bit, so some lanes may update while others keep their value.
- R10: `field_changed` is high for exactly the cycle after a write that updated at least one field, and low after any other cycle.
- R11: A read accepted on one clock edge drives `rsp_valid` high with `rsp_rdata` on the next cycle. `rsp_rdata` reflects the fields as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit word access, 0 = single byte |
| req_addr | input | ADDR_W | Byte offset, equal to the interrupt number |
| req_secure | input | 1 | Secure attribute of the request |
| req_wdata | input | 32 | Write data |
| group_bits | input | NUM_IRQ | Per-interrupt group, 1 = non-secure |
| sec_disable | input | 1 | 1 = single security state |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| field_changed | output | 1 | One-cycle pulse after a field update |

## Verification
The assertions assume that `req_valid` is low throughout reset. They also assume that `group_bits` and `sec_disable` stay stable from a request's edge until its response is checked, because the restricted-view checks relate a response to the attribute and group values of the previous cycle. The bench changes group bits and the security-disable input only between requests, with the request strobe low. It draws addresses from a window slightly wider than the implemented range, so that internal, implemented and unimplemented interrupts all appear in random and directed word and byte traffic.

// File: rtl/prio_fld_pkg.sv
package prio_fld_pkg;

   localparam int LANES  = 4;
   localparam int BYTE_W = 8;
   localparam int WORD_W = LANES * BYTE_W;

   typedef logic [BYTE_W-1:0] prio_t;

   // compressed non-secure view: stored -> visible
   function automatic prio_t ns_view_rd(prio_t stored);
      return {stored[BYTE_W-2:0], 1'b0};
   endfunction

   // compressed non-secure view: written -> stored
   function automatic prio_t ns_view_wr(prio_t written);
      return {1'b1, written[BYTE_W-1:1]};
   endfunction

endpackage

// File: rtl/prio_addr_decode.sv
module prio_addr_decode
   import prio_fld_pkg::*;
#(
   parameter int NUM_IRQ      = 96,
   parameter int NUM_INTERNAL = 32,
   parameter int ADDR_W       = 10,
   localparam int IRQ_W       = ADDR_W + 1
)(
   input  logic [ADDR_W-1:0]            addr,
   input  logic                         word,
   output logic [LANES-1:0][IRQ_W-1:0]  lane_irq,
   output logic [LANES-1:0]             lane_rd_ok,
   output logic [LANES-1:0]             lane_wr_ok,
   output logic                         word_ok
);

   localparam logic [IRQ_W-1:0] LO_IRQ = IRQ_W'(NUM_INTERNAL);
   localparam logic [IRQ_W-1:0] HI_IRQ = IRQ_W'(NUM_IRQ);

   logic [IRQ_W-1:0] base;
   logic [IRQ_W-1:0] last;

   always_comb begin
      base    = {1'b0, addr[ADDR_W-1:2], 2'b00};
      last    = base + IRQ_W'(LANES - 1);
      word_ok = (base >= LO_IRQ) && (last < HI_IRQ);
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic live;
      logic impl;
      always_comb begin
         if (word) begin
            lane_irq[l] = base + IRQ_W'(l);
            live        = 1'b1;
         end else begin
            lane_irq[l] = (l == 0) ? {1'b0, addr} : '0;
            live        = (l == 0);
         end
         impl          = live && (lane_irq[l] >= LO_IRQ) && (lane_irq[l] < HI_IRQ);
         lane_rd_ok[l] = impl;
         lane_wr_ok[l] = impl && (!word || word_ok);
      end
   end

endmodule

// File: rtl/prio_lane_view.sv
module prio_lane_view
   import prio_fld_pkg::*;
(
   input  logic  restricted,
   input  logic  group_ns,
   input  logic  in_range,
   input  prio_t wr_in,
   input  prio_t stored,
   output logic  blocked,
   output prio_t wr_val,
   output prio_t rd_val
);

   always_comb begin
      blocked = restricted && !group_ns;
      if (!in_range || blocked) begin
         rd_val = '0;
      end else if (restricted) begin
         rd_val = ns_view_rd(stored);
      end else begin
         rd_val = stored;
      end
      wr_val = restricted ? ns_view_wr(wr_in) : wr_in;
   end

endmodule

// File: rtl/prio_field_store.sv
module prio_field_store
   import prio_fld_pkg::*;
#(
   parameter int NUM_FIELDS = 64,
   parameter int IDX_W      = 6
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            we,
   input  logic [LANES-1:0][IDX_W-1:0] idx,
   input  logic [LANES-1:0][BYTE_W-1:0] wval,
   output logic [LANES-1:0][BYTE_W-1:0] rval
);

   prio_t fld [NUM_FIELDS];

   for (genvar e = 0; e < NUM_FIELDS; e++) begin : g_fld
      prio_t q;
      logic  hit;
      prio_t nxt;
      always_comb begin
         hit = 1'b0;
         nxt = q;
         for (int l = 0; l < LANES; l++) begin
            if (we[l] && (idx[l] == IDX_W'(e))) begin
               hit = 1'b1;
               nxt = wval[l];
            end
         end
      end
      always_ff @(posedge clk) begin
         if (!rst_n)   q <= '0;
         else if (hit) q <= nxt;
      end
      assign fld[e] = q;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_rd
      always_comb begin
         if (32'(idx[l]) < NUM_FIELDS) rval[l] = fld[idx[l]];
         else                          rval[l] = '0;
      end
   end

endmodule

// File: rtl/prio_field_regs.sv
module prio_field_regs
   import prio_fld_pkg::*;
#(
   parameter int NUM_IRQ      = 96,
   parameter int NUM_INTERNAL = 32,
   parameter int ADDR_W       = 10
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_word,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_secure,
   input  logic [31:0]        req_wdata,
   input  logic [NUM_IRQ-1:0] group_bits,
   input  logic               sec_disable,
   output logic               rsp_valid,
   output logic [31:0]        rsp_rdata,
   output logic               field_changed
);

   localparam int IRQ_W      = ADDR_W + 1;
   localparam int NUM_SHARED = NUM_IRQ - NUM_INTERNAL;
   localparam int IDX_W      = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;
   localparam logic [IRQ_W-1:0] LO_IRQ = IRQ_W'(NUM_INTERNAL);

   if (NUM_IRQ % LANES != 0) begin : g_bad_align
      $error("NUM_IRQ must be a multiple of four");
   end
   if (NUM_INTERNAL % LANES != 0) begin : g_bad_int
      $error("NUM_INTERNAL must be a multiple of four");
   end
   if (NUM_IRQ <= NUM_INTERNAL) begin : g_bad_count
      $error("NUM_IRQ must exceed NUM_INTERNAL");
   end
   if (NUM_IRQ > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for NUM_IRQ");
   end

   logic                         restricted;
   logic [LANES-1:0][IRQ_W-1:0]  lane_irq;
   logic [LANES-1:0]             lane_rd_ok;
   logic [LANES-1:0]             lane_wr_ok;
   logic                         word_ok;
   logic [LANES-1:0]             lane_blocked;
   logic [LANES-1:0]             lane_we;
   logic [LANES-1:0][IDX_W-1:0]  lane_idx;
   logic [LANES-1:0][BYTE_W-1:0] lane_wval;
   logic [LANES-1:0][BYTE_W-1:0] lane_stored;
   logic [LANES-1:0][BYTE_W-1:0] lane_rval;
   logic [31:0]                  rd_word;

   assign restricted = !req_secure && !sec_disable;

   prio_addr_decode #(
      .NUM_IRQ      (NUM_IRQ),
      .NUM_INTERNAL (NUM_INTERNAL),
      .ADDR_W       (ADDR_W)
   ) u_dec (
      .addr       (req_addr),
      .word       (req_word),
      .lane_irq   (lane_irq),
      .lane_rd_ok (lane_rd_ok),
      .lane_wr_ok (lane_wr_ok),
      .word_ok    (word_ok)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [IRQ_W-1:0] off;
      logic             grp;
      prio_t            wr_in;
      always_comb begin
         off         = lane_irq[l] - LO_IRQ;
         lane_idx[l] = off[IDX_W-1:0];
         grp         = lane_rd_ok[l] ? group_bits[lane_irq[l][ADDR_W-1:0]] : 1'b0;
         wr_in       = req_word ? req_wdata[l*BYTE_W +: BYTE_W] : req_wdata[BYTE_W-1:0];
      end

      prio_lane_view u_view (
         .restricted (restricted),
         .group_ns   (grp),
         .in_range   (lane_rd_ok[l]),
         .wr_in      (wr_in),
         .stored     (lane_stored[l]),
         .blocked    (lane_blocked[l]),
         .wr_val     (lane_wval[l]),
         .rd_val     (lane_rval[l])
      );

      assign lane_we[l] = req_valid && req_write && lane_wr_ok[l] && !lane_blocked[l];
   end

   prio_field_store #(
      .NUM_FIELDS (NUM_SHARED),
      .IDX_W      (IDX_W)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lane_we),
      .idx   (lane_idx),
      .wval  (lane_wval),
      .rval  (lane_stored)
   );

   always_comb begin
      if (req_word) rd_word = lane_rval;
      else          rd_word = {24'h0, lane_rval[0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_rdata     <= '0;
         field_changed <= 1'b0;
      end else begin
         rsp_valid     <= req_valid && !req_write;
         field_changed <= |lane_we;
         if (req_valid && !req_write) rsp_rdata <= rd_word;
      end
   end

   // R10
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      field_changed |-> $past(req_valid && req_write));

   // R11
   rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && !req_write));

   // R4
   ns_read_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(restricted)) |-> ((rsp_rdata & 32'h0101_0101) == 32'h0));

   // R7
   word_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && req_write && req_word && !word_ok) |-> !field_changed);

   // R8
   byte_unimpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(!req_word && !lane_rd_ok[0])) |-> (rsp_rdata == 32'h0));

   for (genvar l = 0; l < LANES; l++) begin : g_chk
      // R3
      blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && $past(lane_blocked[l] && lane_rd_ok[l] && (req_word || l == 0)))
            |-> (rsp_rdata[l*BYTE_W +: BYTE_W] == 8'h00));
   end

endmodule

// File: tb/sim_prio_field_regs.sv
`timescale 1ns/1ps
module sim_prio_field_regs;

   localparam int NIRQ = 96;
   localparam int NINT = 32;
   localparam int AW   = 10;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            req_valid, req_write, req_word, req_secure, sec_disable;
   logic [AW-1:0]   req_addr;
   logic [31:0]     req_wdata;
   logic [NIRQ-1:0] group_bits;
   logic            rsp_valid, field_changed;
   logic [31:0]     rsp_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   logic [7:0] mdl [NIRQ];

   always #4 clk = ~clk;

   prio_field_regs #(.NUM_IRQ(NIRQ), .NUM_INTERNAL(NINT), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_word(req_word), .req_addr(req_addr), .req_secure(req_secure),
      .req_wdata(req_wdata), .group_bits(group_bits), .sec_disable(sec_disable),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .field_changed(field_changed));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   function automatic bit restr(input bit sec);
      return !sec && !sec_disable;
   endfunction

   function automatic logic [7:0] view(input int irq, input bit sec);
      if (irq < NINT || irq >= NIRQ) return 8'h00;
      if (restr(sec) && !group_bits[irq]) return 8'h00;
      if (restr(sec)) return {mdl[irq][6:0], 1'b0};
      return mdl[irq];
   endfunction

   // returns 1 when the field gets updated
   function automatic bit apply(input int irq, input bit sec, input logic [7:0] b);
      if (irq < NINT || irq >= NIRQ) return 0;
      if (restr(sec) && !group_bits[irq]) return 0;
      mdl[irq] = restr(sec) ? {1'b1, b[7:1]} : b;
      return 1;
   endfunction

   task automatic access(input bit wr, input bit wd, input int addr, input bit sec,
                         input logic [31:0] wdata, input string tag);
      logic [31:0] exp_rd;
      bit          exp_chg;
      int          base;
      exp_rd  = '0;
      exp_chg = 0;
      base    = addr & ~3;
      if (!wr) begin
         if (wd) for (int l = 0; l < 4; l++) exp_rd[l*8 +: 8] = view(base + l, sec);
         else    exp_rd[7:0] = view(addr, sec);
      end
      @(negedge clk);
      req_valid = 1; req_write = wr; req_word = wd; req_addr = AW'(addr);
      req_secure = sec; req_wdata = wdata;
      @(posedge clk);
      if (wr) begin
         if (wd) begin
            if (base >= NINT && base + 3 < NIRQ)
               for (int l = 0; l < 4; l++)
                  if (apply(base + l, sec, wdata[l*8 +: 8])) exp_chg = 1;
         end else begin
            exp_chg = apply(addr, sec, wdata[7:0]);
         end
      end
      @(negedge clk);
      req_valid = 0;
      chk(field_changed == exp_chg, {tag, " R10 change pulse"}, 32'(field_changed), 32'(exp_chg));
      chk(rsp_valid == !wr, {tag, " R11 response valid"}, 32'(rsp_valid), 32'(!wr));
      if (!wr) chk(rsp_rdata == exp_rd, {tag, " read data"}, rsp_rdata, exp_rd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 0; req_valid = 0; req_write = 0; req_word = 0; req_addr = '0;
      req_secure = 0; req_wdata = '0; sec_disable = 0; group_bits = '0;
      for (int i = 0; i < NIRQ; i++) mdl[i] = 8'h00;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(rsp_valid == 0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
      chk(field_changed == 0, "R1 pulse after reset", 32'(field_changed), 0);
      for (int a = NINT; a < NIRQ; a += 4) access(0, 1, a, 1, 0, "R1 reset word");

      // R2 secure and security-disabled pass-through
      access(1, 1, 40, 1, 32'hF1E2_D3C4, "R2 secure write");
      access(0, 1, 40, 1, 0, "R2 secure read");
      sec_disable = 1;
      access(1, 0, 50, 0, 32'h0000_0037, "R2 disabled write");
      access(0, 0, 50, 0, 0, "R2 disabled read");
      sec_disable = 0;

      // R3 restricted to group 0
      group_bits = '0;
      access(1, 0, 41, 0, 32'h0000_00AA, "R3 blocked write");
      access(0, 0, 41, 1, 0, "R3 field kept");
      access(0, 0, 41, 0, 0, "R3 blocked read");

      // R4 R5 restricted to group 1
      group_bits[44] = 1;
      access(1, 0, 44, 0, 32'h0000_0066, "R5 ns write");
      access(0, 0, 44, 1, 0, "R5 stored view");
      access(0, 0, 44, 0, 0, "R4 ns read");

      // R9 mixed lanes
      group_bits[60] = 1; group_bits[62] = 1;
      access(1, 1, 60, 1, 32'h1111_1111, "R9 seed");
      access(1, 1, 60, 0, 32'h8844_2200, "R9 mixed write");
      access(0, 1, 60, 1, 0, "R9 mixed read");

      // R6 unaligned word address
      access(1, 1, 67, 1, 32'hA0B0_C0D0, "R6 unaligned write");
      access(0, 1, 64, 1, 0, "R6 lane order");
      access(0, 0, 66, 1, 0, "R6 byte of lane 2");

      // R7 dropped word writes
      access(1, 1, 28, 1, 32'h5555_5555, "R7 low drop");
      access(1, 1, 96, 1, 32'h5555_5555, "R7 high drop");
      access(0, 1, 28, 1, 0, "R7 low read");
      access(0, 1, 92, 1, 0, "R7 top word read");

      // R8 byte to internal / unimplemented
      access(1, 0, 5, 1, 32'h0000_00FF, "R8 internal write");
      access(0, 0, 5, 1, 0, "R8 internal read");
      access(1, 0, 100, 1, 32'h0000_00FF, "R8 unimpl write");
      access(0, 0, 100, 1, 0, "R8 unimpl read");
      access(1, 0, 95, 1, 32'h0000_0077, "R8 last field");
      access(0, 0, 95, 1, 0, "R8 last field read");

      // random traffic
      for (int i = 0; i < 600; i++) begin
         if ((i % 50) == 0) begin
            @(negedge clk);
            for (int g = 0; g < NIRQ; g++) group_bits[g] = 1'($urandom_range(0, 1));
            sec_disable = ($urandom_range(0, 7) == 0);
         end
         access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 111)), 1'($urandom_range(0, 1)),
                $urandom(), "R2 random");
      end

      @(negedge clk);
      chk(field_changed == 0, "R10 idle pulse low", 32'(field_changed), 0);
      finish_run();
   end

endmodule